// File: doc/BRIEF.md
# Dual-Buffer Ethernet Transmit Front-End

This block is the transmit half of a small Ethernet MAC seen through a 32-bit word bus. Software fills one of two frame buffers with bus writes, sets the frame length for that buffer's port, and then writes the port's control word. The control word holds one of two commands. A plain start streams the buffer out, one byte per handshake, on a byte-wide valid/ready frame interface that marks the final byte. A start combined with the program bit instead loads the first six buffer bytes into the station address register. No bytes go out on the frame interface for that command.

Each port has its own length, interrupt-enable and control words. Both ports share one sequencer. A command written while the other port's command is running stays pending and runs after it. The command bits read back as set until the command has finished, and then they clear. When a command finishes, a one-cycle interrupt pulse can be raised. This needs the interrupt-enable bit in that port's control word, and it also needs the global enable bit held in port 0's enable word. The bus reads buffer words and registers with one cycle of latency. Only aligned full-word accesses take effect.

Top module: `mac_tx_front`

## Requirements
- R1: After reset, every length, enable and control word reads 0, `tx_valid`, `tx_last` and `irq` are low, and `mac_addr` equals the `MAC_RESET` parameter.
- R2: `bus_addr[11]` selects the port (0 or 1) and `bus_addr[12]` must be 0. Within a port, word index `bus_addr[10:2]` 0..508 is the frame buffer, 509 is the length word, 510 is the enable word and 511 is the control word. Byte offset 4w+k sits in bits [8k+7:8k] of buffer word w. Accesses with `bus_addr[12]`=1 change nothing and read 0.
- R3: Read data appears on `bus_rdata` one cycle after the request. The length and enable words read back all 32 bits as written, and buffer words read back as written.
- R4: A control write with bit 0 (start) = 1 and bit 1 (program) = 0 streams the port's buffer bytes 0..L-1 in address order, where L is the length word, and raises `tx_last` with the final byte.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R6: A length of 0 completes without emitting a byte. A length above 2036 (the buffer size) is treated as 2036.
- R7: A control write with start = 1 and program = 1 copies buffer bytes 0..5 into `mac_addr`, with byte i in bits [8i+7:8i], and emits nothing on the frame interface.
- R8: The start and program bits read 1 while their command is pending or running and 0 once it finishes, and the other control bits keep the written value. A control write with start = 0 stores both bits as 0 and starts nothing.
- R9: A control write to a port whose start bit still reads 1 is ignored entirely.
- R10: A command written while the other port's command is running waits, then runs in full once that command completes.
- R11: When a command completes, `irq` pulses high for one cycle if control bit 3 of that port is set and bit 31 of port 0's enable word is set. Port 1's enable word has no effect on `irq`.
- R12: A write with `bus_be` not equal to 4'hF, or with `bus_addr[1:0]` not 0, changes nothing, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| tx_ready | input | 1 | Frame sink accepts a byte |
| tx_valid | output | 1 | A frame byte is offered |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Offered byte is the last of the frame |
| irq | output | 1 | One-cycle completion interrupt |
| mac_addr | output | 48 | Station address register |

## Verification
The embedded properties watch the frame interface on every cycle. They check that an offered byte holds steady under backpressure and that `tx_last` never appears without `tx_valid`. They also check that a running command's control word does not change until its completion, that partial writes leave the length and enable words alone, and that the interrupt lasts one cycle and never fires without the global enable. They check, too, that the station address moves only while a program command is active. The byte order of a frame, clamping of the length, the order in which queued commands run across the ports, the address loaded by a program command, and the decision to raise or hold back the interrupt can only be shown by the bench's scenarios, which compare every accepted byte against a behavioural model of the buffers.

// File: rtl/mac_tx_pkg.sv
package mac_tx_pkg;
  localparam int unsigned CTRL_START = 0;
  localparam int unsigned CTRL_PROG  = 1;
  localparam int unsigned CTRL_IE    = 3;
  localparam int unsigned GIE_BIT    = 31;
  localparam int unsigned NPORT      = 2;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD,
    SQ_OUT,
    SQ_MRD0,
    SQ_MRD1,
    SQ_MCAP,
    SQ_DONE
  } seq_state_e;
endpackage

// File: rtl/mac_tx_bufram.sv
module mac_tx_bufram #(
  parameter int unsigned DEPTH = 509,
  parameter int unsigned AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_port,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          a_en,
  input  logic          a_port,
  input  logic [AW-1:0] a_addr,
  output logic [31:0]   a_data,
  input  logic          b_en,
  input  logic          b_port,
  input  logic [AW-1:0] b_addr,
  output logic [31:0]   b_data
);
  logic [1:0][31:0] a_word;
  logic [1:0][31:0] b_word;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_port == 1'(g))) begin
        mem[wr_addr] <= wr_data;
      end
    end

    assign a_word[g] = (32'(a_addr) < DEPTH) ? mem[a_addr] : '0;
    assign b_word[g] = (32'(b_addr) < DEPTH) ? mem[b_addr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_data <= '0;
      b_data <= '0;
    end else begin
      if (a_en) a_data <= a_word[a_port];
      if (b_en) b_data <= b_word[b_port];
    end
  end
endmodule

// File: rtl/mac_tx_regs.sv
module mac_tx_regs
  import mac_tx_pkg::*;
#(
  parameter int unsigned SEL_BIT   = 11,
  parameter int unsigned BUF_WORDS = 509,
  localparam int unsigned AW       = SEL_BIT - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [SEL_BIT+1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic              done,
  input  logic              done_port,
  output logic              ram_wr_en,
  output logic              ram_port,
  output logic [AW-1:0]     ram_addr,
  output logic              ram_rd_en,
  output logic              rd_buf_q,
  output logic [31:0]       rdata_q,
  output logic [1:0][31:0]  len_o,
  output logic [1:0]        start_o,
  output logic [1:0]        prog_o,
  output logic              irq
);
  logic [1:0][31:0] len_q, len_d;
  logic [1:0][31:0] gie_q, gie_d;
  logic [1:0][31:0] ctrl_q, ctrl_d;
  logic             irq_d;
  logic [31:0]      rdata_d;
  logic             rd_buf_d;
  logic             acc_ok, wr_ok, rd_ok, port;
  logic [AW-1:0]    wi;
  logic             is_buf, is_len, is_gie, is_ctrl;

  assign port    = bus_addr[SEL_BIT];
  assign wi      = bus_addr[SEL_BIT-1:2];
  assign acc_ok  = bus_req && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00)
                   && !bus_addr[SEL_BIT+1];
  assign wr_ok   = acc_ok && bus_we;
  assign rd_ok   = acc_ok && !bus_we;
  assign is_buf  = 32'(wi) < BUF_WORDS;
  assign is_len  = 32'(wi) == BUF_WORDS;
  assign is_gie  = 32'(wi) == BUF_WORDS + 1;
  assign is_ctrl = 32'(wi) == BUF_WORDS + 2;

  assign ram_wr_en = wr_ok && is_buf;
  assign ram_rd_en = rd_ok && is_buf;
  assign ram_port  = port;
  assign ram_addr  = wi;

  always_comb begin
    len_d  = len_q;
    gie_d  = gie_q;
    ctrl_d = ctrl_q;
    for (int p = 0; p < 2; p++) begin
      if (done && (done_port == 1'(p))) begin
        ctrl_d[p][CTRL_PROG:CTRL_START] = 2'b00;
      end
      if (wr_ok && (port == 1'(p))) begin
        if (is_len) len_d[p] = bus_wdata;
        if (is_gie) gie_d[p] = bus_wdata;
        if (is_ctrl && !ctrl_q[p][CTRL_START]) begin
          ctrl_d[p] = {bus_wdata[31:2],
                       bus_wdata[CTRL_START] ? bus_wdata[1:0] : 2'b00};
        end
      end
    end
  end

  always_comb begin
    rdata_d  = rdata_q;
    rd_buf_d = rd_buf_q;
    if (bus_req && !bus_we) begin
      rd_buf_d = rd_ok && is_buf;
      rdata_d  = '0;
      if (rd_ok) begin
        if (is_len)  rdata_d = len_q[port];
        if (is_gie)  rdata_d = gie_q[port];
        if (is_ctrl) rdata_d = ctrl_q[port];
      end
    end
  end

  assign irq_d = done && ctrl_q[done_port][CTRL_IE] && gie_q[0][GIE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      gie_q    <= '0;
      ctrl_q   <= '0;
      rdata_q  <= '0;
      rd_buf_q <= 1'b0;
      irq      <= 1'b0;
    end else begin
      len_q    <= len_d;
      gie_q    <= gie_d;
      ctrl_q   <= ctrl_d;
      rdata_q  <= rdata_d;
      rd_buf_q <= rd_buf_d;
      irq      <= irq_d;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_out
    assign len_o[g]   = len_q[g];
    assign start_o[g] = ctrl_q[g][CTRL_START];
    assign prog_o[g]  = ctrl_q[g][CTRL_PROG];

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[g][CTRL_START] && !(done && (done_port == 1'(g))))
      |=> (ctrl_q[g][CTRL_START] && $stable(ctrl_q[g][31:2])));
  end

  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie_q[0][GIE_BIT]));
  a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ctrl_q[done_port][CTRL_START]);
  a_r12_partial_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && (bus_be != 4'hF)) |=> ($stable(len_q) && $stable(gie_q)));
endmodule

// File: rtl/mac_tx_seq.sv
module mac_tx_seq
  import mac_tx_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 509,
  parameter logic [47:0] MAC_RESET = 48'h0,
  localparam int unsigned AW        = $clog2(BUF_WORDS),
  localparam int unsigned BUF_BYTES = BUF_WORDS * 4,
  localparam int unsigned CW        = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       start_in,
  input  logic [1:0]       prog_in,
  input  logic [1:0][31:0] len_in,
  input  logic [31:0]      ram_data,
  output logic             ram_en,
  output logic             ram_port,
  output logic [AW-1:0]    ram_addr,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             done,
  output logic             done_port,
  output logic [47:0]      mac_addr
);
  seq_state_e    state_q, state_d;
  logic          port_q, port_d;
  logic [AW-1:0] word_q, word_d;
  logic [1:0]    bsel_q, bsel_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_q, len_d;
  logic [47:0]   mac_q, mac_d;
  logic          pick;
  logic [CW-1:0] pick_len;

  function automatic logic [CW-1:0] clamp_len(input logic [31:0] l);
    if (l > 32'(BUF_BYTES)) return CW'(BUF_BYTES);
    return l[CW-1:0];
  endfunction

  assign pick     = start_in[0] ? 1'b0 : 1'b1;
  assign pick_len = clamp_len(len_in[pick]);

  always_comb begin
    state_d  = state_q;
    port_d   = port_q;
    word_d   = word_q;
    bsel_d   = bsel_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    mac_d    = mac_q;
    ram_en   = 1'b0;
    ram_addr = word_q;
    tx_valid = 1'b0;
    tx_last  = 1'b0;
    tx_data  = ram_data[{bsel_q, 3'b000} +: 8];
    done     = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (|start_in) begin
          port_d = pick;
          word_d = '0;
          bsel_d = '0;
          cnt_d  = '0;
          len_d  = pick_len;
          if (prog_in[pick])      state_d = SQ_MRD0;
          else if (pick_len == 0) state_d = SQ_DONE;
          else                    state_d = SQ_RD;
        end
      end
      SQ_RD: begin
        ram_en  = 1'b1;
        state_d = SQ_OUT;
      end
      SQ_OUT: begin
        tx_valid = 1'b1;
        tx_last  = (cnt_q == len_q - 1'b1);
        if (tx_ready) begin
          cnt_d = cnt_q + 1'b1;
          if (tx_last) begin
            state_d = SQ_DONE;
          end else if (bsel_q == 2'd3) begin
            bsel_d  = '0;
            word_d  = word_q + 1'b1;
            state_d = SQ_RD;
          end else begin
            bsel_d = bsel_q + 1'b1;
          end
        end
      end
      SQ_MRD0: begin
        ram_en   = 1'b1;
        ram_addr = '0;
        state_d  = SQ_MRD1;
      end
      SQ_MRD1: begin
        mac_d[31:0] = ram_data;
        ram_en      = 1'b1;
        ram_addr    = AW'(1);
        state_d     = SQ_MCAP;
      end
      SQ_MCAP: begin
        mac_d[47:32] = ram_data[15:0];
        state_d      = SQ_DONE;
      end
      SQ_DONE: begin
        done    = 1'b1;
        state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  assign ram_port  = port_q;
  assign done_port = port_q;
  assign mac_addr  = mac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      port_q  <= 1'b0;
      word_q  <= '0;
      bsel_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      mac_q   <= MAC_RESET;
    end else begin
      state_q <= state_d;
      port_q  <= port_d;
      word_q  <= word_d;
      bsel_q  <= bsel_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      mac_q   <= mac_d;
    end
  end

  a_r5_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  a_r4_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  a_r7_mac_on_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_q != $past(mac_q)) |-> $past(prog_in[port_q]));
endmodule

// File: rtl/mac_tx_front.sv
module mac_tx_front
  import mac_tx_pkg::*;
#(
  parameter int unsigned SEL_BIT   = 11,
  parameter logic [47:0] MAC_RESET = 48'h0000_5E00_FA02,
  localparam int unsigned ADDR_W    = SEL_BIT + 2,
  localparam int unsigned AW        = SEL_BIT - 2,
  localparam int unsigned BUF_WORDS = (2 ** AW) - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              irq,
  output logic [47:0]       mac_addr
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             ram_wr_en, ram_a_en, ram_a_port, ram_b_en, ram_b_port;
  logic [AW-1:0]    ram_a_addr, ram_b_addr;
  logic [31:0]      ram_a_data, ram_b_data;
  logic             rd_buf_q;
  logic [31:0]      reg_rdata;
  logic [1:0][31:0] len_w;
  logic [1:0]       start_w, prog_w;
  logic             done, done_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mac_tx_regs #(.SEL_BIT(SEL_BIT), .BUF_WORDS(BUF_WORDS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .done      (done),
    .done_port (done_port),
    .ram_wr_en (ram_wr_en),
    .ram_port  (ram_a_port),
    .ram_addr  (ram_a_addr),
    .ram_rd_en (ram_a_en),
    .rd_buf_q  (rd_buf_q),
    .rdata_q   (reg_rdata),
    .len_o     (len_w),
    .start_o   (start_w),
    .prog_o    (prog_w),
    .irq       (irq)
  );

  mac_tx_bufram #(.DEPTH(BUF_WORDS), .AW(AW)) u_ram (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (ram_wr_en),
    .wr_port (ram_a_port),
    .wr_addr (ram_a_addr),
    .wr_data (bus_wdata),
    .a_en    (ram_a_en),
    .a_port  (ram_a_port),
    .a_addr  (ram_a_addr),
    .a_data  (ram_a_data),
    .b_en    (ram_b_en),
    .b_port  (ram_b_port),
    .b_addr  (ram_b_addr),
    .b_data  (ram_b_data)
  );

  mac_tx_seq #(.BUF_WORDS(BUF_WORDS), .MAC_RESET(MAC_RESET)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_in  (start_w),
    .prog_in   (prog_w),
    .len_in    (len_w),
    .ram_data  (ram_b_data),
    .ram_en    (ram_b_en),
    .ram_port  (ram_b_port),
    .ram_addr  (ram_b_addr),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .done      (done),
    .done_port (done_port),
    .mac_addr  (mac_addr)
  );

  assign bus_rdata = rd_buf_q ? ram_a_data : reg_rdata;
endmodule

// File: tb/test_mac_tx_front.sv
module test_mac_tx_front;
  localparam logic [47:0] MACR = 48'h0000_5E00_FA02;
  localparam int BUFB = 2036;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_ready = 1'b0;
  logic        tx_valid, tx_last, irq;
  logic [7:0]  tx_data;
  logic [47:0] mac_addr;

  int errors = 0, checks = 0;
  int exp_irq = 0, irq_seen = 0, cycles = 0;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [7:0] memb [2][BUFB];
  logic [7:0] exp_q [$];
  logic       expl_q [$];
  logic       gie0_on = 1'b0;

  always #5 clk = ~clk;

  mac_tx_front i_mac_tx_front (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .irq(irq), .mac_addr(mac_addr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Reference model of the frame interface, compared on every clock.
  always @(negedge clk) begin
    cycles++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (ready_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = lfsr[0] | lfsr[2];
      default: tx_ready = 1'b0;
    endcase
    if (irq) irq_seen++;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected byte", {56'h0, tx_data}, 64'h0);
      end else begin
        logic [7:0] eb;
        logic       el;
        eb = exp_q.pop_front();
        el = expl_q.pop_front();
        check(tx_data == eb, "R4 frame byte", {56'h0, tx_data}, {56'h0, eb});
        check(tx_last == el, "R4 last flag", {63'h0, tx_last}, {63'h0, el});
      end
    end
    if (cycles > 150000) begin
      check(1'b0, "watchdog", 64'(cycles), 64'd150000);
      finish_run();
    end
  end

  task automatic bus_wr(input logic [12:0] a, input logic [31:0] d,
                        input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [12:0] a, output logic [31:0] d,
                        input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    d = bus_rdata;
    bus_req = 1'b0;
  endtask

  function automatic logic [12:0] reg_a(input int p, input int idx);
    return 13'((p << 11) | ((509 + idx) << 2));
  endfunction

  task automatic fill_word(input int p, input int w, input logic [31:0] d);
    bus_wr(13'((p << 11) | (w << 2)), d);
    for (int k = 0; k < 4; k++) memb[p][4*w+k] = d[8*k +: 8];
  endtask

  task automatic send(input int p, input int len, input bit ie);
    int n;
    bus_wr(reg_a(p, 0), 32'(len));
    n = (len > BUFB) ? BUFB : len;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(memb[p][i]);
      expl_q.push_back(i == n - 1);
    end
    if (ie && gie0_on) exp_irq++;
    bus_wr(reg_a(p, 2), {28'h0, ie, 3'b001});
  endtask

  task automatic wait_idle(input int p);
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      bus_rd(reg_a(p, 2), v);
      if (!v[0]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    logic [47:0] em;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(tx_valid == 1'b0 && irq == 1'b0, "R1 outputs idle", {62'h0, tx_valid, irq}, 64'h0);
    check(mac_addr == MACR, "R1 mac reset", 64'(mac_addr), 64'(MACR));
    for (int p = 0; p < 2; p++) for (int r = 0; r < 3; r++) begin
      bus_rd(reg_a(p, r), v);
      check(v == 0, "R1 register zero", 64'(v), 64'h0);
    end

    // R2/R3 map and readback
    bus_wr(reg_a(1, 1), 32'hDEAD_BEEF);
    bus_rd(reg_a(1, 1), v);
    check(v == 32'hDEAD_BEEF, "R3 enable word readback", 64'(v), 64'hDEADBEEF);
    bus_rd(reg_a(0, 1), v);
    check(v == 0, "R2 port select", 64'(v), 64'h0);
    fill_word(1, 3, 32'h1234_5678);
    bus_rd(13'h0800 | 13'(3 << 2), v);
    check(v == 32'h1234_5678, "R3 buffer readback", 64'(v), 64'h12345678);
    bus_wr(13'h1000 | reg_a(1, 1), 32'h0);
    bus_rd(13'h1000 | reg_a(1, 1), v);
    check(v == 0, "R2 high window reads zero", 64'(v), 64'h0);
    bus_rd(reg_a(1, 1), v);
    check(v == 32'hDEAD_BEEF, "R2 high window write ignored", 64'(v), 64'hDEADBEEF);

    // R4/R11 basic send port 0 with interrupt
    bus_wr(reg_a(0, 1), 32'h8000_0000);
    gie0_on = 1'b1;
    for (int w = 0; w < 10; w++) fill_word(0, w, 32'h0302_0100 + 32'(w) * 32'h0404_0404);
    send(0, 5, 1'b1);
    wait_idle(0);
    check(exp_q.size() == 0, "R4 frame complete", 64'(exp_q.size()), 64'h0);
    check(irq_seen == exp_irq, "R11 irq on completion", 64'(irq_seen), 64'(exp_irq));

    // R5 backpressure, port 1, ie clear
    for (int w = 0; w < 5; w++) fill_word(1, w, 32'hA0B0_C0D0 ^ (32'(w) << 3));
    ready_mode = 1;
    send(1, 13, 1'b0);
    wait_idle(1);
    ready_mode = 0;
    check(exp_q.size() == 0, "R5 stalled frame complete", 64'(exp_q.size()), 64'h0);
    check(irq_seen == exp_irq, "R11 no irq without ie", 64'(irq_seen), 64'(exp_irq));

    // R6 zero length
    send(0, 0, 1'b1);
    wait_idle(0);
    check(irq_seen == exp_irq, "R6 zero length completes", 64'(irq_seen), 64'(exp_irq));

    // R6 clamp
    for (int w = 0; w < 509; w++) fill_word(1, w, {16'(w), 16'(w * 7 + 1)});
    send(1, 3000, 1'b0);
    wait_idle(1);
    check(exp_q.size() == 0, "R6 clamped length", 64'(exp_q.size()), 64'h0);

    // R7/R8 program station address
    fill_word(0, 0, 32'h4433_2211);
    fill_word(0, 1, 32'h0000_6655);
    exp_irq++;
    bus_wr(reg_a(0, 2), 32'h0000_000B);
    wait_idle(0);
    for (int i = 0; i < 6; i++) em[8*i +: 8] = memb[0][i];
    check(mac_addr == em, "R7 mac loaded", 64'(mac_addr), 64'(em));
    check(exp_q.size() == 0, "R7 no frame bytes", 64'(exp_q.size()), 64'h0);
    bus_rd(reg_a(0, 2), v);
    check(v == 32'h8, "R8 command bits self-clear", 64'(v), 64'h8);
    check(irq_seen == exp_irq, "R11 irq after program", 64'(irq_seen), 64'(exp_irq));

    // R8/R9/R10 busy handling with queued command on port 1
    ready_mode = 2;
    repeat (2) @(negedge clk);
    send(0, 3, 1'b0);
    bus_rd(reg_a(0, 2), v);
    check(v == 32'h1, "R8 start reads 1 while running", 64'(v), 64'h1);
    bus_wr(reg_a(0, 2), 32'h0000_0009);
    bus_rd(reg_a(0, 2), v);
    check(v == 32'h1, "R9 busy write ignored", 64'(v), 64'h1);
    send(1, 4, 1'b0);
    bus_rd(reg_a(1, 2), v);
    check(v == 32'h1, "R10 second port pending", 64'(v), 64'h1);
    ready_mode = 0;
    wait_idle(0);
    wait_idle(1);
    check(exp_q.size() == 0, "R10 both frames in order", 64'(exp_q.size()), 64'h0);
    bus_rd(reg_a(0, 2), v);
    check(v == 32'h0, "R9 ignored write left no trace", 64'(v), 64'h0);

    // R8 program without start
    bus_wr(reg_a(1, 2), 32'h0000_0002);
    repeat (4) @(negedge clk);
    bus_rd(reg_a(1, 2), v);
    check(v == 32'h0, "R8 no command without start", 64'(v), 64'h0);
    check(mac_addr == em, "R8 mac untouched", 64'(mac_addr), 64'(em));

    // R11 port 1 enable word ignored
    bus_wr(reg_a(0, 1), 32'h0);
    gie0_on = 1'b0;
    bus_wr(reg_a(1, 1), 32'h8000_0000);
    send(0, 2, 1'b1);
    wait_idle(0);
    check(irq_seen == exp_irq, "R11 port1 enable ignored", 64'(irq_seen), 64'(exp_irq));

    // R12 partial and misaligned accesses
    bus_wr(reg_a(0, 0), 32'h55, 4'h3);
    bus_wr(reg_a(0, 0) | 13'h1, 32'h77);
    bus_rd(reg_a(0, 0), v);
    check(v == 32'h2, "R12 partial write ignored", 64'(v), 64'h2);
    bus_rd(reg_a(0, 0), v, 4'h1);
    check(v == 32'h0, "R12 partial read zero", 64'(v), 64'h0);

    check(exp_q.size() == 0 && !tx_valid, "R4 interface quiet at end", 64'(exp_q.size()), 64'h0);
    finish_run();
  end
endmodule